// File: doc/BRIEF.md
# In-Order Three-Slot Decode Steering

This block sits between an instruction queue and a bank of three decoders. Each cycle it looks at the three oldest queued instruction descriptors. It decides which of them are handed to a decoder, and it tells the queue how many entries to pop. Each descriptor arrives already classified. The descriptor carries a valid bit, a flag saying the instruction is simple, a flag saying it touches memory, and the number of micro-ops it expands into.

Slot 0 serves the queue head and takes any valid instruction. Slots 1 and 2 are restricted. They take only an instruction that is simple, does not touch memory, and becomes exactly one micro-op. Steering is strictly in program order. The first entry that cannot go to its slot stops that entry and every younger entry for this cycle. A blocked complex instruction waits until it reaches the head, where the general slot takes it.

All outputs are combinational, so the pop count reaches the queue in the same cycle. A low downstream ready withholds every grant.

Top module: `dsteer_top`

## Requirements
- R1: While `ready` is low, `grant` is 000, `consume` is 0 and `uop_total` is 0.
- R2: With `ready` high and entry 0 valid, `grant[0]` is 1 whatever the entry's simple flag, memory flag and micro-op count are.
- R3: `grant[k]` for k = 1 or 2 is 1 only if entry k is valid, simple, not a memory instruction, and has a micro-op count of exactly 1.
- R4: Grants form a prefix: `grant[k]` set implies `grant[k-1]` set.
- R5: An entry that is ineligible for its restricted slot blocks all younger entries for the cycle, even simple single-micro-op ones.
- R6: An invalid entry at position 1 or 2 ends the group in the same way as an ineligible one.
- R7: `consume` equals the number of set `grant` bits, from 0 to 3.
- R8: `uop_total` equals the sum of the micro-op counts of the granted entries. It is 0 when nothing is granted.
- R9: An invalid head entry produces no grants.
- R10: A set memory flag makes an entry ineligible for a restricted slot, even if it is flagged simple with one micro-op.
- R11: A simple entry whose micro-op count is not 1 is ineligible for a restricted slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the embedded checks |
| rst_n | input | 1 | Asynchronous active-low reset, gates the embedded checks |
| ready | input | 1 | Downstream decoders can accept work |
| in_valid | input | 3 | Entry k holds an instruction (bit k = queue position k, 0 = head) |
| in_simple | input | 3 | Entry k is a simple instruction |
| in_mem | input | 3 | Entry k touches memory |
| in_uops | input | 9 | Micro-op count of entry k in bits [3k+2:3k] |
| grant | output | 3 | Entry k is steered to slot k this cycle |
| consume | output | 2 | Number of entries the queue pops this cycle |
| uop_total | output | 5 | Micro-ops produced by the granted entries |

## Verification
The clocked checks assume the descriptor inputs are settled and known at each rising edge. They also assume that the valid, simple and memory flags are independent bits, so any combination is legal, including a simple instruction that touches memory. The stimulus changes inputs just after a rising edge and samples outputs at the falling edge. It draws every flag and every 3-bit count freely, so the checks see all combinations, including zero and large micro-op counts.

// File: rtl/dsteer_pkg.sv
package dsteer_pkg;

  // Capability of a decode slot.
  typedef enum logic [0:0] {
    SLOT_GENERAL    = 1'b0,
    SLOT_RESTRICTED = 1'b1
  } slot_kind_e;

  function automatic slot_kind_e slot_kind(input int idx);
    return (idx == 0) ? SLOT_GENERAL : SLOT_RESTRICTED;
  endfunction

endpackage

// File: rtl/dsteer_classify.sv
module dsteer_classify
  import dsteer_pkg::*;
#(
  parameter int SLOTS = 3,
  parameter int UOP_W = 3
) (
  input  logic [SLOTS-1:0]       in_valid,
  input  logic [SLOTS-1:0]       in_simple,
  input  logic [SLOTS-1:0]       in_mem,
  input  logic [SLOTS*UOP_W-1:0] in_uops,
  output logic [SLOTS-1:0]       elig
);

  localparam logic [UOP_W-1:0] ONE_UOP = UOP_W'(1);

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (slot_kind(k) == SLOT_GENERAL) begin : g_general
      assign elig[k] = in_valid[k];
    end else begin : g_restricted
      logic [UOP_W-1:0] cnt;
      assign cnt     = in_uops[k*UOP_W +: UOP_W];
      assign elig[k] = in_valid[k] & in_simple[k] & ~in_mem[k] & (cnt == ONE_UOP);
    end
  end

endmodule

// File: rtl/dsteer_prefix.sv
module dsteer_prefix #(
  parameter int SLOTS = 3,
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic [SLOTS-1:0] elig,
  output logic [SLOTS-1:0] grant,
  output logic [CNT_W-1:0] consume
);

  always_comb begin
    logic run;
    run     = ready;
    consume = '0;
    for (int k = 0; k < SLOTS; k++) begin
      grant[k] = run & elig[k];
      run      = grant[k];
      consume  = consume + CNT_W'(grant[k]);
    end
  end

  // R1: backpressure withholds every grant
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (grant == '0 && consume == '0));

  // R4: grants are a contiguous run from the head
  for (genvar k = 1; k < SLOTS; k++) begin : g_chk
    p_prefix_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grant[k] |-> grant[k-1]);
  end

endmodule

// File: rtl/dsteer_uop_sum.sv
module dsteer_uop_sum #(
  parameter int SLOTS = 3,
  parameter int UOP_W = 3,
  parameter int SUM_W = $clog2(SLOTS * ((1 << UOP_W) - 1) + 1)
) (
  input  logic [SLOTS-1:0]       grant,
  input  logic [SLOTS*UOP_W-1:0] in_uops,
  output logic [SUM_W-1:0]       uop_total
);

  always_comb begin
    uop_total = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (grant[k]) uop_total = uop_total + SUM_W'(in_uops[k*UOP_W +: UOP_W]);
    end
  end

endmodule

// File: rtl/dsteer_top.sv
module dsteer_top #(
  parameter int SLOTS = 3,
  parameter int UOP_W = 3,
  parameter int CNT_W = $clog2(SLOTS + 1),
  parameter int SUM_W = $clog2(SLOTS * ((1 << UOP_W) - 1) + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ready,
  input  logic [SLOTS-1:0]       in_valid,
  input  logic [SLOTS-1:0]       in_simple,
  input  logic [SLOTS-1:0]       in_mem,
  input  logic [SLOTS*UOP_W-1:0] in_uops,
  output logic [SLOTS-1:0]       grant,
  output logic [CNT_W-1:0]       consume,
  output logic [SUM_W-1:0]       uop_total
);

  logic [SLOTS-1:0] elig;

  dsteer_classify #(.SLOTS(SLOTS), .UOP_W(UOP_W)) u_class (
    .in_valid (in_valid),
    .in_simple(in_simple),
    .in_mem   (in_mem),
    .in_uops  (in_uops),
    .elig     (elig)
  );

  dsteer_prefix #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_prefix (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready  (ready),
    .elig   (elig),
    .grant  (grant),
    .consume(consume)
  );

  dsteer_uop_sum #(.SLOTS(SLOTS), .UOP_W(UOP_W), .SUM_W(SUM_W)) u_sum (
    .grant    (grant),
    .in_uops  (in_uops),
    .uop_total(uop_total)
  );

  // R2: a valid head always goes out when downstream is ready
  p_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && in_valid[0]) |-> grant[0]);

  // R9: nothing leaves without a valid head
  p_nohead_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid[0] |-> (grant == '0));

  // R3, R10, R11: restricted slots only see single-uop register work
  for (genvar k = 1; k < SLOTS; k++) begin : g_rchk
    p_restricted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grant[k] |-> (in_valid[k] && in_simple[k] && !in_mem[k]
                    && in_uops[k*UOP_W +: UOP_W] == UOP_W'(1)));
  end

  // R7: pop count agrees with the grant vector
  p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == int'(consume));

  // R8: no micro-ops appear without a granted entry
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (consume == '0) |-> (uop_total == '0));

endmodule

// File: tb/dsteer_top_test.sv
module dsteer_top_test;

  localparam int SLOTS = 3;
  localparam int UOP_W = 3;
  localparam int NVEC  = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ready;
  logic [2:0] in_valid, in_simple, in_mem;
  logic [8:0] in_uops;
  logic [2:0] grant;
  logic [1:0] consume;
  logic [4:0] uop_total;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  dsteer_top uut (
    .clk(clk), .rst_n(rst_n), .ready(ready),
    .in_valid(in_valid), .in_simple(in_simple), .in_mem(in_mem), .in_uops(in_uops),
    .grant(grant), .consume(consume), .uop_total(uop_total)
  );

  // Entry code: [5] valid, [4] simple, [3] memory, [2:0] micro-op count
  localparam logic [5:0] E_S  = 6'b110001; // simple, one uop
  localparam logic [5:0] E_C  = 6'b100100; // complex, four uops
  localparam logic [5:0] E_M  = 6'b111001; // simple-flagged memory op
  localparam logic [5:0] E_S2 = 6'b110010; // simple, two uops
  localparam logic [5:0] E_NV = 6'b000000; // empty

  // {ready, e0, e1, e2, grant, consume, uop_total}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b1, E_S,  E_S,  E_S,  3'b111, 2'd3, 5'd3},
    {1'b1, E_C,  E_S,  E_S,  3'b111, 2'd3, 5'd6},
    {1'b1, E_S,  E_C,  E_S,  3'b001, 2'd1, 5'd1},
    {1'b1, E_S,  E_S,  E_C,  3'b011, 2'd2, 5'd2},
    {1'b1, E_S,  E_M,  E_S,  3'b001, 2'd1, 5'd1},
    {1'b1, E_S,  E_NV, E_S,  3'b001, 2'd1, 5'd1},
    {1'b1, E_NV, E_S,  E_S,  3'b000, 2'd0, 5'd0},
    {1'b0, E_S,  E_S,  E_S,  3'b000, 2'd0, 5'd0},
    {1'b1, E_M,  E_S,  E_S,  3'b111, 2'd3, 5'd3},
    {1'b1, E_S,  E_S2, E_S,  3'b001, 2'd1, 5'd1}
  };

  task automatic check(input string req, input logic [2:0] g, input logic [1:0] c,
                       input logic [4:0] u);
    total++;
    if (grant !== g || consume !== c || uop_total !== u) begin
      bad++;
      $display("FAIL %s: grant=%b consume=%0d uops=%0d expected grant=%b consume=%0d uops=%0d",
               req, grant, consume, uop_total, g, c, u);
    end
  endtask

  task automatic drive(input logic r, input logic [5:0] e0, input logic [5:0] e1,
                       input logic [5:0] e2);
    @(posedge clk);
    #1;
    ready     = r;
    in_valid  = {e2[5], e1[5], e0[5]};
    in_simple = {e2[4], e1[4], e0[4]};
    in_mem    = {e2[3], e1[3], e0[3]};
    in_uops   = {e2[2:0], e1[2:0], e0[2:0]};
    @(negedge clk);
  endtask

  // Reference rule written from the requirements
  task automatic model(input logic r, input logic [5:0] e [3], output logic [2:0] g,
                       output logic [1:0] c, output logic [4:0] u);
    logic go;
    go = r;
    g = '0; c = '0; u = '0;
    for (int k = 0; k < 3; k++) begin
      logic ok;
      if (k == 0) ok = e[k][5];
      else ok = e[k][5] && e[k][4] && !e[k][3] && e[k][2:0] == 3'd1;
      go = go && ok;
      if (go) begin
        g[k] = 1'b1;
        c    = c + 2'd1;
        u    = u + {2'b00, e[k][2:0]};
      end
    end
  endtask

  initial begin
    #150000;
    bad++;
    total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ready = 1'b0;
    in_valid = '0; in_simple = '0; in_mem = '0; in_uops = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset", 3'b000, 2'd0, 5'd0);
    #1 rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      case (i)
        0: tag = "R7";  1: tag = "R2";  2: tag = "R5";  3: tag = "R8";
        4: tag = "R10"; 5: tag = "R6";  6: tag = "R9";  7: tag = "R1";
        8: tag = "R2";  default: tag = "R11";
      endcase
      drive(VEC[i][28], VEC[i][27:22], VEC[i][21:16], VEC[i][15:10]);
      check(tag, VEC[i][9:7], VEC[i][6:5], VEC[i][4:0]);
    end

    // R3: zero-uop simple entry is not single-uop, so slot 1 refuses it
    drive(1'b1, E_S, 6'b110000, E_S);
    check("R3", 3'b001, 2'd1, 5'd1);
    // R8: large head count summed with two singles
    drive(1'b1, 6'b100111, E_S, E_S);
    check("R8", 3'b111, 2'd3, 5'd9);
    // R5: blocking at slot 2 with memory op after it
    drive(1'b1, E_C, E_S, E_M);
    check("R5", 3'b011, 2'd2, 5'd5);

    // R4 and R7: random mixes against the reference rule
    for (int n = 0; n < 400; n++) begin
      logic [5:0] e [3];
      logic       r;
      logic [2:0] g;
      logic [1:0] c;
      logic [4:0] u;
      r = ($urandom_range(0, 7) != 0);
      for (int k = 0; k < 3; k++) begin
        e[k] = 6'($urandom);
        if ($urandom_range(0, 1) == 1) e[k] = E_S;
      end
      model(r, e, g, c, u);
      drive(r, e[0], e[1], e[2]);
      check("R4 random", g, c, u);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule